// File: doc/BRIEF.md
# Masked Packed Signed Minimum Unit

This block is a vector datapath stage. It compares two source vectors element by element as two's-complement integers and writes the smaller value of each pair into a destination vector of up to 512 bits. The caller picks the element width (32 or 64 bits) and the active vector length (128, 256 or 512 bits). A per-element writemask decides which elements take the new result. Elements that are masked off either keep their previous destination value or are cleared. A broadcast option compares every element against the lowest element of the second source.

A legacy option copies an older register-to-register form of the operation. The previous destination value serves as the first operand, the width is fixed at 128 bits, and everything above bit 127 is preserved. The previous destination contents arrive on an input port. A result is captured whenever `in_valid` is high and appears one clock later with `out_valid`. The block produces no status flags.

Top module: `vmin_masked_unit`

## Requirements
- R1: Each element compares as a signed two's-complement integer. The first operand's element is written only when it is strictly less than the second operand's element. Otherwise, including when they are equal, the second operand's element is written.
- R2: `elem64`=0 selects 32-bit elements and `elem64`=1 selects 64-bit elements. Element j occupies bits [j*W +: W]. `vlen_sel` 0, 1 and 2 (and 3) select 128, 256 and 512 bits. The active element count is the vector length divided by W.
- R3: With `mask_en`=0 every active element is written. With `mask_en`=1, active element j is written only when `wmask[j]` is 1. With 64-bit elements only `wmask[7:0]` is used. Mask bits at or beyond the active element count have no effect.
- R4: An active element that is not written keeps its `dst_old` value when `zero_en`=0, and reads as zero when `zero_en`=1.
- R5: With `bcast_en`=1 (and `legacy_en`=0), every element's second operand is element 0 of `src_b`.
- R6: With `legacy_en`=0, every destination bit at or above the active vector length is zero.
- R7: With `legacy_en`=1, the vector length is 128 bits and `dst_old` supplies the first operand, so `src_a` is ignored. `mask_en`, `zero_en` and `bcast_en` have no effect, and `dst_out[511:128]` equals `dst_old[511:128]`.
- R8: A cycle with `in_valid`=1 gives `out_valid`=1 and the result on the next clock. A cycle with `in_valid`=0 gives `out_valid`=0 on the next clock, and `dst_out` holds its value.
- R9: A synchronous active-high `rst` clears `out_valid` and `dst_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands valid; the result is captured |
| elem64 | input | 1 | 0: 32-bit elements, 1: 64-bit elements |
| vlen_sel | input | 2 | Vector length: 0=128, 1=256, 2/3=512 |
| legacy_en | input | 1 | Legacy 128-bit form with upper bits preserved |
| mask_en | input | 1 | Enable the per-element writemask |
| zero_en | input | 1 | Masked-off elements: 1 clear, 0 keep old |
| bcast_en | input | 1 | Use the lowest element of src_b for every element |
| wmask | input | 16 | Per-element writemask |
| src_a | input | 512 | First source vector |
| src_b | input | 512 | Second source vector |
| dst_old | input | 512 | Previous destination value |
| out_valid | output | 1 | Result valid |
| dst_out | output | 512 | Result vector |

## Verification
Broadcast and writemasking can act on the same operation. In that case the broadcast element decides the minimum of the written elements, while the masked-off elements must still show `dst_old` or zero and never the broadcast value. The bench sets both options together in directed and random operations. It also runs the legacy form with both options set, where neither may have any effect. Each result is judged against a bench model that works element by element, with its own width and sign handling.

// File: rtl/vmin_pkg.sv
package vmin_pkg;
  localparam int DATA_W   = 512;
  localparam int SLOT_W   = 32;
  localparam int CHUNK_W  = 2 * SLOT_W;
  localparam int NSLOT    = DATA_W / SLOT_W;
  localparam int NCHUNK   = DATA_W / CHUNK_W;
  localparam int MASK_W   = NSLOT;
  localparam int LEGACY_W = 128;
  localparam int CNT_W    = $clog2(NSLOT) + 1;

  typedef enum logic [1:0] {
    VL_128  = 2'd0,
    VL_256  = 2'd1,
    VL_512  = 2'd2,
    VL_512X = 2'd3
  } vlen_e;

  function automatic logic [SLOT_W-1:0] smin_slot(input logic [SLOT_W-1:0] a,
                                                   input logic [SLOT_W-1:0] b);
    return ($signed(a) < $signed(b)) ? a : b;
  endfunction

  function automatic logic [CHUNK_W-1:0] smin_chunk(input logic [CHUNK_W-1:0] a,
                                                     input logic [CHUNK_W-1:0] b);
    return ($signed(a) < $signed(b)) ? a : b;
  endfunction

  // number of active 32-bit slots
  function automatic logic [CNT_W-1:0] active_slots(input vlen_e v, input logic legacy);
    if (legacy) return CNT_W'(LEGACY_W / SLOT_W);
    case (v)
      VL_128:  return CNT_W'(128 / SLOT_W);
      VL_256:  return CNT_W'(256 / SLOT_W);
      default: return CNT_W'(512 / SLOT_W);
    endcase
  endfunction
endpackage

// File: rtl/vmin_ctl.sv
module vmin_ctl
  import vmin_pkg::*;
(
  input  logic              elem64,
  input  logic [1:0]        vlen_sel,
  input  logic              legacy,
  input  logic              mask_en,
  input  logic [MASK_W-1:0] wmask,
  output logic [NSLOT-1:0]  slot_inrange,
  output logic [NSLOT-1:0]  slot_wr
);
  logic [CNT_W-1:0] n_act;

  always_comb n_act = active_slots(vlen_e'(vlen_sel), legacy);

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic mbit;
    assign mbit            = elem64 ? wmask[s/2] : wmask[s];
    assign slot_inrange[s] = (CNT_W'(s) < n_act);
    assign slot_wr[s]      = slot_inrange[s] & (legacy | ~mask_en | mbit);
  end
endmodule

// File: rtl/vmin_chunk.sv
module vmin_chunk
  import vmin_pkg::*;
(
  input  logic               elem64,
  input  logic               legacy,
  input  logic               zero_eff,
  input  logic [CHUNK_W-1:0] a,
  input  logic [CHUNK_W-1:0] b,
  input  logic [CHUNK_W-1:0] old,
  input  logic [1:0]         wr,
  input  logic [1:0]         inrange,
  output logic [CHUNK_W-1:0] res
);
  logic [CHUNK_W-1:0] min_wide;
  logic [CHUNK_W-1:0] min_pair;
  logic [CHUNK_W-1:0] min_sel;

  assign min_wide = smin_chunk(a, b);
  assign min_pair = {smin_slot(a[CHUNK_W-1:SLOT_W], b[CHUNK_W-1:SLOT_W]),
                     smin_slot(a[SLOT_W-1:0], b[SLOT_W-1:0])};
  assign min_sel  = elem64 ? min_wide : min_pair;

  for (genvar h = 0; h < 2; h++) begin : g_half
    always_comb begin
      if (!inrange[h])
        res[h*SLOT_W +: SLOT_W] = legacy ? old[h*SLOT_W +: SLOT_W] : '0;
      else if (wr[h])
        res[h*SLOT_W +: SLOT_W] = min_sel[h*SLOT_W +: SLOT_W];
      else
        res[h*SLOT_W +: SLOT_W] = zero_eff ? '0 : old[h*SLOT_W +: SLOT_W];
    end
  end
endmodule

// File: rtl/vmin_masked_unit.sv
module vmin_masked_unit
  import vmin_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              elem64,
  input  logic [1:0]        vlen_sel,
  input  logic              legacy_en,
  input  logic              mask_en,
  input  logic              zero_en,
  input  logic              bcast_en,
  input  logic [MASK_W-1:0] wmask,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [DATA_W-1:0] dst_old,
  output logic              out_valid,
  output logic [DATA_W-1:0] dst_out
);
  logic [NSLOT-1:0]  slot_inrange;
  logic [NSLOT-1:0]  slot_wr;
  logic [DATA_W-1:0] a_eff;
  logic [DATA_W-1:0] b_eff;
  logic [DATA_W-1:0] b_rep;
  logic [DATA_W-1:0] res_next;
  logic              zero_eff;

  vmin_ctl u_ctl (
    .elem64       (elem64),
    .vlen_sel     (vlen_sel),
    .legacy       (legacy_en),
    .mask_en      (mask_en),
    .wmask        (wmask),
    .slot_inrange (slot_inrange),
    .slot_wr      (slot_wr)
  );

  assign b_rep    = elem64 ? {NCHUNK{src_b[CHUNK_W-1:0]}} : {NSLOT{src_b[SLOT_W-1:0]}};
  assign a_eff    = legacy_en ? dst_old : src_a;
  assign b_eff    = (bcast_en && !legacy_en) ? b_rep : src_b;
  assign zero_eff = mask_en & zero_en & ~legacy_en;

  for (genvar c = 0; c < NCHUNK; c++) begin : g_chunk
    vmin_chunk u_chunk (
      .elem64   (elem64),
      .legacy   (legacy_en),
      .zero_eff (zero_eff),
      .a        (a_eff[c*CHUNK_W +: CHUNK_W]),
      .b        (b_eff[c*CHUNK_W +: CHUNK_W]),
      .old      (dst_old[c*CHUNK_W +: CHUNK_W]),
      .wr       (slot_wr[2*c +: 2]),
      .inrange  (slot_inrange[2*c +: 2]),
      .res      (res_next[c*CHUNK_W +: CHUNK_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      dst_out   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) dst_out <= res_next;
    end
  end
endmodule

// File: rtl/vmin_chk.sv
module vmin_chk
  import vmin_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              elem64,
  input logic [1:0]        vlen_sel,
  input logic              legacy_en,
  input logic              mask_en,
  input logic              zero_en,
  input logic [MASK_W-1:0] wmask,
  input logic [DATA_W-1:0] dst_old,
  input logic              out_valid,
  input logic [DATA_W-1:0] dst_out,
  input logic [NSLOT-1:0]  slot_wr
);
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> !out_valid && dst_out == '0); // R9
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && $stable(dst_out)); // R8
  AST_MASK_GATES_WRITE: assert property (@(posedge clk) disable iff (rst)
    mask_en && !legacy_en && !elem64 |-> (slot_wr & ~wmask) == '0); // R3
  AST_ZERO_MASKED_LANE: assert property (@(posedge clk) disable iff (rst)
    in_valid && !legacy_en && mask_en && zero_en && !elem64 && !wmask[0]
    |=> dst_out[SLOT_W-1:0] == '0); // R4
  AST_UPPER_CLEAR_128: assert property (@(posedge clk) disable iff (rst)
    in_valid && !legacy_en && vlen_sel == 2'd0 |=> dst_out[DATA_W-1:128] == '0); // R6
  AST_UPPER_CLEAR_256: assert property (@(posedge clk) disable iff (rst)
    in_valid && !legacy_en && vlen_sel == 2'd1 |=> dst_out[DATA_W-1:256] == '0); // R6
  AST_LEGACY_UPPER_KEPT: assert property (@(posedge clk) disable iff (rst)
    in_valid && legacy_en |=> dst_out[DATA_W-1:LEGACY_W] == $past(dst_old[DATA_W-1:LEGACY_W])); // R7
endmodule

bind vmin_masked_unit vmin_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .elem64    (elem64),
  .vlen_sel  (vlen_sel),
  .legacy_en (legacy_en),
  .mask_en   (mask_en),
  .zero_en   (zero_en),
  .wmask     (wmask),
  .dst_old   (dst_old),
  .out_valid (out_valid),
  .dst_out   (dst_out),
  .slot_wr   (slot_wr)
);

// File: tb/vmin_masked_unit_tb.sv
module vmin_masked_unit_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         elem64 = 1'b0;
  logic [1:0]   vlen_sel = 2'd0;
  logic         legacy_en = 1'b0;
  logic         mask_en = 1'b0;
  logic         zero_en = 1'b0;
  logic         bcast_en = 1'b0;
  logic [15:0]  wmask = '0;
  logic [511:0] src_a = '0;
  logic [511:0] src_b = '0;
  logic [511:0] dst_old = '0;
  logic         out_valid;
  logic [511:0] dst_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vmin_masked_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .elem64(elem64), .vlen_sel(vlen_sel),
    .legacy_en(legacy_en), .mask_en(mask_en), .zero_en(zero_en), .bcast_en(bcast_en),
    .wmask(wmask), .src_a(src_a), .src_b(src_b), .dst_old(dst_old),
    .out_valid(out_valid), .dst_out(dst_out)
  );

  function automatic logic [63:0] pick(input logic [511:0] v, input int j, input int w);
    logic [63:0] x;
    x = '0;
    for (int k = 0; k < w; k++) x[k] = v[j*w + k];
    return x;
  endfunction

  function automatic longint as_signed(input logic [63:0] x, input int w);
    if (w == 32) return longint'({{32{x[31]}}, x[31:0]});
    return longint'(x);
  endfunction

  function automatic logic [511:0] model(input logic e64, input logic [1:0] vs,
      input logic leg, input logic me, input logic ze, input logic bc,
      input logic [15:0] wm, input logic [511:0] a, input logic [511:0] b,
      input logic [511:0] o);
    logic [511:0] r;
    int w;
    int vl;
    r  = '0;
    w  = e64 ? 64 : 32;
    vl = leg ? 128 : (vs == 2'd0 ? 128 : (vs == 2'd1 ? 256 : 512));
    for (int j = 0; j < 512 / w; j++) begin
      logic [63:0] xa, xb, xo, v;
      xa = pick(leg ? o : a, j, w);
      xb = (bc && !leg) ? pick(b, 0, w) : pick(b, j, w);
      xo = pick(o, j, w);
      if (j * w >= vl)                 v = leg ? xo : 64'd0;
      else if (leg || !me || wm[j])    v = (as_signed(xa, w) < as_signed(xb, w)) ? xa : xb;
      else                             v = ze ? 64'd0 : xo;
      for (int k = 0; k < w; k++) r[j*w + k] = v[k];
    end
    return r;
  endfunction

  function automatic logic [511:0] r512();
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom();
    return v;
  endfunction

  task automatic check(input string tag, input logic ok, input logic [511:0] got,
                       input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s valid=%0b got=%h exp=%h", tag, out_valid, got, exp);
    end
  endtask

  // drive at a falling edge, capture on the next rising edge, judge at the next falling edge
  task automatic run_op(input string tag);
    logic [511:0] exp;
    exp = model(elem64, vlen_sel, legacy_en, mask_en, zero_en, bcast_en, wmask,
                src_a, src_b, dst_old);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, out_valid === 1'b1 && dst_out === exp, dst_out, exp);
  endtask

  task automatic set_mode(input logic e, input logic [1:0] v, input logic l, input logic m,
                          input logic z, input logic b, input logic [15:0] wm);
    elem64 = e; vlen_sel = v; legacy_en = l; mask_en = m; zero_en = z; bcast_en = b; wmask = wm;
  endtask

  initial begin
    #500us;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [511:0] held;
    void'($urandom(32'd7311));
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || dst_out !== '0) begin
      errors++;
      $display("FAIL R9 reset got valid=%0b dst=%h exp valid=0 dst=0", out_valid, dst_out);
    end
    rst = 1'b0;
    @(negedge clk);

    // R1: 32-bit sign: 0x80000000 is negative, below 1
    src_a = r512(); src_b = r512(); dst_old = r512();
    src_a[31:0] = 32'h8000_0000; src_b[31:0] = 32'h0000_0001;
    src_a[63:32] = 32'h0000_0005; src_b[63:32] = 32'h0000_0005;
    set_mode(1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000);
    run_op("R1 signed32");
    // R2: same bits as 64-bit elements are positive
    set_mode(1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000);
    run_op("R2 signed64");
    // R3: mask bits above the active count ignored (128-bit, 32-bit elements)
    set_mode(1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 16'hFFF5);
    run_op("R3 mask128");
    set_mode(1'b1, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 16'hFF06);
    run_op("R3 mask64");
    // R4: merge then zero
    set_mode(1'b0, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 16'hA5C3);
    run_op("R4 merge");
    set_mode(1'b0, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 16'hA5C3);
    run_op("R4 zero");
    // R5: broadcast with and without masking
    set_mode(1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0000);
    run_op("R5 bcast32");
    set_mode(1'b1, 2'd2, 1'b0, 1'b1, 1'b1, 1'b1, 16'h005A);
    run_op("R5 bcast64 zero-mask");
    // R6: upper bits cleared
    set_mode(1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000);
    run_op("R6 vl256");
    set_mode(1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0003);
    run_op("R6 vl128");
    // R7: legacy ignores src_a, mask, broadcast, keeps upper bits
    set_mode(1'b0, 2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0000);
    run_op("R7 legacy");
    set_mode(1'b1, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000);
    run_op("R7 legacy64");

    // R8: idle cycle keeps the result and drops out_valid
    held = dst_out;
    src_a = r512(); src_b = r512(); dst_old = r512();
    @(negedge clk);
    check("R8 idle hold", out_valid === 1'b0 && dst_out === held, dst_out, held);

    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [3:0] k;
      src_a = r512(); src_b = r512(); dst_old = r512();
      k = 4'($urandom());
      if (k[1:0] == 2'd0) src_b = src_a;
      if (k[3:2] == 2'd0) src_b = src_a ^ {16{32'h0000_0001}};
      set_mode(1'($urandom()), 2'($urandom()), ($urandom() % 6) == 0, 1'($urandom()),
               1'($urandom()), ($urandom() % 3) == 0, 16'($urandom()));
      run_op("R1 R2 R3 R4 R5 R6 R7 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule